// File: doc/BRIEF.md
# Per-Warp Register Scoreboard with Long-Latency Tagging

This block records which destination registers of each warp still have a write outstanding. An issue stage uses it to hold back instructions that would read or overwrite such a register. When an instruction issues, its destination registers are reserved. When its results are written back, those registers are released. A collision query tells the issue logic whether a candidate instruction touches any register that is still pending.

Alongside the pending set, each warp has a second set: the registers whose outstanding write comes from a load that must travel to slow memory. These are loads from the global, local or texture spaces. A warp scheduler asks, for one register, whether it is in this set, and can move a warp aside when that warp depends on such a load. The long-latency set is coarse. Any release on a warp empties that warp's whole set, even when the release names other registers.

Both queries are combinational reads of the stored state. Reserve and release take effect at the next clock edge.

Top module: `warp_scoreboard`

## Requirements
- R1: A synchronous active-high reset clears every pending bit and every long-latency bit, so after reset both queries return 0 for every warp and register.
- R2: A reserve sets the pending bit of each used destination slot of the given warp. A slot is used when its register number is nonzero. The bit is visible to the collision query from the cycle after the reserve.
- R3: A reserve that is a load with space code 0 (global), 1 (local) or 5 (texture) also sets the long-latency bit of each used destination slot. From the next cycle the long-latency query returns 1 for those registers.
- R4: A reserve that is not a load, or is a load with space code 2 (shared), 3 (constant) or 4 (parameter), sets pending bits only and leaves the long-latency query at 0 for those registers.
- R5: A release clears the pending bits of its used register slots in the given warp and leaves every other pending bit unchanged.
- R6: Any release on a warp clears that warp's entire long-latency set, including registers the release did not name.
- R7: When a reserve and a release in the same cycle target the same warp, the reserve wins on every bit both would change. Its pending bits are set, and its long-latency bits are set after the wipe.
- R8: The collision query returns 1 when any nonzero register among its four source slots or four destination slots has its pending bit set in the queried warp, and 0 otherwise.
- R9: Register number 0 marks an unused slot. It is never reserved, a query slot holding 0 never causes a collision, and the long-latency query for register 0 returns 0.
- R10: Reserves and releases on one warp leave the pending and long-latency state of every other warp unchanged.
- R11: A register that the long-latency query reports is always also pending, so a collision query naming it in the same warp returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsvValid | input | 1 | Reserve strobe |
| rsvWarp | input | 4 | Warp of the reserving instruction |
| rsvRegs | input | 24 | Four 6-bit destination register numbers; slot i at bits [6i+5:6i] |
| rsvIsLoad | input | 1 | Reserving instruction is a load |
| rsvSpace | input | 3 | Memory space code of the load (0 global, 1 local, 2 shared, 3 constant, 4 parameter, 5 texture) |
| relValid | input | 1 | Release strobe |
| relWarp | input | 4 | Warp of the releasing instruction |
| relRegs | input | 24 | Four 6-bit register numbers to release, same packing |
| colWarp | input | 4 | Warp for the collision query |
| colSrcRegs | input | 24 | Four 6-bit source register numbers of the candidate instruction |
| colDstRegs | input | 24 | Four 6-bit destination register numbers of the candidate instruction |
| colHit | output | 1 | Candidate touches a pending register |
| llWarp | input | 4 | Warp for the long-latency query |
| llReg | input | 6 | Register for the long-latency query |
| llHit | output | 1 | Register awaits a long-latency load |

## Verification
A reserve and a release can land in the same cycle. The hard case is when both hit the same warp, and especially the same register. The bench provokes this on purpose. It releases a register while re-reserving it as a global load in the same cycle. It also releases on one warp while reserving on another. On the following cycle it judges the result from both queries, against a reference model that applies the release first and the reserve on top. Randomized traffic then mixes the two operations freely over a few warps and low register numbers, so that overlaps keep recurring.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [2:0] {
    SPACE_GLOBAL   = 3'd0,
    SPACE_LOCAL    = 3'd1,
    SPACE_SHARED   = 3'd2,
    SPACE_CONST    = 3'd3,
    SPACE_PARAM    = 3'd4,
    SPACE_TEXTURE  = 3'd5
  } memSpace_t;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic rsvEn;   // reserve applies this cycle
    logic llTag;   // reserve also tags long-latency bits
    logic relEn;   // release applies this cycle
  } sbStrobe_t;

  function automatic logic isLongSpace(input logic [2:0] space);
    return (space == SPACE_GLOBAL) || (space == SPACE_LOCAL) ||
           (space == SPACE_TEXTURE);
  endfunction

endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS  = 64,
  parameter int REG_SLOTS = 4,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                       rsvValid,
  input  logic [REG_SLOTS*REG_W-1:0] rsvRegs,
  input  logic                       rsvIsLoad,
  input  logic [2:0]                 rsvSpace,
  input  logic                       relValid,
  input  logic [REG_SLOTS*REG_W-1:0] relRegs,
  output sbStrobe_t                  strobe,
  output logic [NUM_REGS-1:0]        rsvMask,
  output logic [NUM_REGS-1:0]        relMask
);

  logic [REG_SLOTS-1:0][NUM_REGS-1:0] rsvSlotMask;
  logic [REG_SLOTS-1:0][NUM_REGS-1:0] relSlotMask;

  // One decoder per operand slot; register 0 decodes to nothing
  for (genvar s = 0; s < REG_SLOTS; s++) begin : g_slot
    logic [REG_W-1:0] rsvNum;
    logic [REG_W-1:0] relNum;
    assign rsvNum = rsvRegs[s*REG_W +: REG_W];
    assign relNum = relRegs[s*REG_W +: REG_W];
    always_comb begin
      rsvSlotMask[s] = '0;
      relSlotMask[s] = '0;
      if (rsvNum != '0) rsvSlotMask[s][rsvNum] = 1'b1;
      if (relNum != '0) relSlotMask[s][relNum] = 1'b1;
    end
  end

  always_comb begin
    rsvMask = '0;
    relMask = '0;
    for (int s = 0; s < REG_SLOTS; s++) begin
      rsvMask |= rsvSlotMask[s];
      relMask |= relSlotMask[s];
    end
  end

  always_comb begin
    strobe.rsvEn = rsvValid;
    strobe.llTag = rsvValid && rsvIsLoad && isLongSpace(rsvSpace);
    strobe.relEn = relValid;
  end

endmodule

// File: rtl/sb_dp.sv
module sb_dp
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int NUM_REGS  = 64,
  parameter int QRY_SLOTS = 4,
  localparam int WARP_W   = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  sbStrobe_t                  strobe,
  input  logic [WARP_W-1:0]          rsvWarp,
  input  logic [NUM_REGS-1:0]        rsvMask,
  input  logic [WARP_W-1:0]          relWarp,
  input  logic [NUM_REGS-1:0]        relMask,
  input  logic [WARP_W-1:0]          colWarp,
  input  logic [QRY_SLOTS*REG_W-1:0] colSrcRegs,
  input  logic [QRY_SLOTS*REG_W-1:0] colDstRegs,
  output logic                       colHit,
  input  logic [WARP_W-1:0]          llWarp,
  input  logic [REG_W-1:0]           llReg,
  output logic                       llHit
);

  logic [NUM_REGS-1:0] pendRow [NUM_WARPS];
  logic [NUM_REGS-1:0] llRow   [NUM_WARPS];

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic rsvHere;
    logic relHere;
    logic [NUM_REGS-1:0] pendNext;
    logic [NUM_REGS-1:0] llNext;

    assign rsvHere = strobe.rsvEn && (rsvWarp == WARP_W'(w));
    assign relHere = strobe.relEn && (relWarp == WARP_W'(w));

    // Release first, reserve on top: reserve wins on shared bits
    always_comb begin
      pendNext = pendRow[w];
      llNext   = llRow[w];
      if (relHere) begin
        pendNext = pendNext & ~relMask;
        llNext   = '0;
      end
      if (rsvHere) begin
        pendNext = pendNext | rsvMask;
        if (strobe.llTag) llNext = llNext | rsvMask;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pendRow[w] <= '0;
        llRow[w]   <= '0;
      end else begin
        pendRow[w] <= pendNext;
        llRow[w]   <= llNext;
      end
    end
  end

  logic [NUM_REGS-1:0] colRow;
  logic [NUM_REGS-1:0] llSel;
  assign colRow = pendRow[colWarp];
  assign llSel  = llRow[llWarp];

  always_comb begin
    colHit = 1'b0;
    for (int s = 0; s < QRY_SLOTS; s++) begin
      if (colSrcRegs[s*REG_W +: REG_W] != '0 && colRow[colSrcRegs[s*REG_W +: REG_W]])
        colHit = 1'b1;
      if (colDstRegs[s*REG_W +: REG_W] != '0 && colRow[colDstRegs[s*REG_W +: REG_W]])
        colHit = 1'b1;
    end
  end

  assign llHit = (llReg != '0) && llSel[llReg];

endmodule

// File: rtl/warp_scoreboard.sv
module warp_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int NUM_REGS  = 64,
  parameter int REG_SLOTS = 4,
  localparam int WARP_W   = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rsvValid,
  input  logic [WARP_W-1:0]          rsvWarp,
  input  logic [REG_SLOTS*REG_W-1:0] rsvRegs,
  input  logic                       rsvIsLoad,
  input  logic [2:0]                 rsvSpace,
  input  logic                       relValid,
  input  logic [WARP_W-1:0]          relWarp,
  input  logic [REG_SLOTS*REG_W-1:0] relRegs,
  input  logic [WARP_W-1:0]          colWarp,
  input  logic [REG_SLOTS*REG_W-1:0] colSrcRegs,
  input  logic [REG_SLOTS*REG_W-1:0] colDstRegs,
  output logic                       colHit,
  input  logic [WARP_W-1:0]          llWarp,
  input  logic [REG_W-1:0]           llReg,
  output logic                       llHit
);

  sbStrobe_t           strobe;
  logic [NUM_REGS-1:0] rsvMask;
  logic [NUM_REGS-1:0] relMask;

  sb_ctrl #(.NUM_REGS(NUM_REGS), .REG_SLOTS(REG_SLOTS)) u_ctrl (
    .rsvValid  (rsvValid),
    .rsvRegs   (rsvRegs),
    .rsvIsLoad (rsvIsLoad),
    .rsvSpace  (rsvSpace),
    .relValid  (relValid),
    .relRegs   (relRegs),
    .strobe    (strobe),
    .rsvMask   (rsvMask),
    .relMask   (relMask)
  );

  sb_dp #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .QRY_SLOTS(REG_SLOTS)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .rsvWarp    (rsvWarp),
    .rsvMask    (rsvMask),
    .relWarp    (relWarp),
    .relMask    (relMask),
    .colWarp    (colWarp),
    .colSrcRegs (colSrcRegs),
    .colDstRegs (colDstRegs),
    .colHit     (colHit),
    .llWarp     (llWarp),
    .llReg      (llReg),
    .llHit      (llHit)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_WARPS = 16,
  parameter int NUM_REGS  = 64,
  parameter int REG_SLOTS = 4,
  localparam int WARP_W   = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rsvValid,
  input logic [WARP_W-1:0]          rsvWarp,
  input logic [REG_SLOTS*REG_W-1:0] rsvRegs,
  input logic                       rsvIsLoad,
  input logic [2:0]                 rsvSpace,
  input logic                       relValid,
  input logic [WARP_W-1:0]          relWarp,
  input logic [WARP_W-1:0]          colWarp,
  input logic [REG_SLOTS*REG_W-1:0] colSrcRegs,
  input logic [REG_SLOTS*REG_W-1:0] colDstRegs,
  input logic                       colHit,
  input logic [WARP_W-1:0]          llWarp,
  input logic [REG_W-1:0]           llReg,
  input logic                       llHit
);

  logic longRsv;
  assign longRsv = rsvValid && rsvIsLoad &&
                   (rsvSpace == 3'd0 || rsvSpace == 3'd1 || rsvSpace == 3'd5);

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!colHit && !llHit));  // R1

  AST_RSV_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    ($past(rsvValid) && $past(rsvRegs[REG_W-1:0]) != '0 &&
     colWarp == $past(rsvWarp) && colSrcRegs[REG_W-1:0] == $past(rsvRegs[REG_W-1:0]))
    |-> colHit);  // R2

  AST_LONG_TAGGED: assert property (@(posedge clk) disable iff (rst)
    ($past(longRsv) && $past(rsvRegs[REG_W-1:0]) != '0 &&
     llWarp == $past(rsvWarp) && llReg == $past(rsvRegs[REG_W-1:0]))
    |-> llHit);  // R3

  AST_RELEASE_WIPES: assert property (@(posedge clk) disable iff (rst)
    ($past(relValid) && !$past(rsvValid) && llWarp == $past(relWarp))
    |-> !llHit);  // R6

  AST_ZERO_UNUSED_COL: assert property (@(posedge clk) disable iff (rst)
    (colSrcRegs == '0 && colDstRegs == '0) |-> !colHit);  // R9

  AST_ZERO_UNUSED_LL: assert property (@(posedge clk) disable iff (rst)
    (llReg == '0) |-> !llHit);  // R9

  AST_LONG_IMPLIES_PEND: assert property (@(posedge clk) disable iff (rst)
    (llHit && colWarp == llWarp && colSrcRegs[REG_W-1:0] == llReg) |-> colHit);  // R11

endmodule

bind warp_scoreboard sb_checker #(
  .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .REG_SLOTS(REG_SLOTS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rsvValid   (rsvValid),
  .rsvWarp    (rsvWarp),
  .rsvRegs    (rsvRegs),
  .rsvIsLoad  (rsvIsLoad),
  .rsvSpace   (rsvSpace),
  .relValid   (relValid),
  .relWarp    (relWarp),
  .colWarp    (colWarp),
  .colSrcRegs (colSrcRegs),
  .colDstRegs (colDstRegs),
  .colHit     (colHit),
  .llWarp     (llWarp),
  .llReg      (llReg),
  .llHit      (llHit)
);

// File: tb/warp_scoreboard_tb.sv
`timescale 1ns/1ps
module warp_scoreboard_tb;

  localparam int NW = 16;
  localparam int NR = 64;
  localparam int NS = 4;
  localparam int RW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rsvValid = 1'b0;
  logic [3:0] rsvWarp = '0;
  logic [NS*RW-1:0] rsvRegs = '0;
  logic rsvIsLoad = 1'b0;
  logic [2:0] rsvSpace = '0;
  logic relValid = 1'b0;
  logic [3:0] relWarp = '0;
  logic [NS*RW-1:0] relRegs = '0;
  logic [3:0] colWarp = '0;
  logic [NS*RW-1:0] colSrcRegs = '0;
  logic [NS*RW-1:0] colDstRegs = '0;
  logic colHit;
  logic [3:0] llWarp = '0;
  logic [RW-1:0] llReg = '0;
  logic llHit;

  always #4 clk = ~clk;

  warp_scoreboard u_dut (
    .clk(clk), .rst(rst),
    .rsvValid(rsvValid), .rsvWarp(rsvWarp), .rsvRegs(rsvRegs),
    .rsvIsLoad(rsvIsLoad), .rsvSpace(rsvSpace),
    .relValid(relValid), .relWarp(relWarp), .relRegs(relRegs),
    .colWarp(colWarp), .colSrcRegs(colSrcRegs), .colDstRegs(colDstRegs),
    .colHit(colHit), .llWarp(llWarp), .llReg(llReg), .llHit(llHit)
  );

  // Reference model: plain bit tables
  bit mPend [NW][NR];
  bit mLong [NW][NR];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  function automatic int slotOf(input logic [NS*RW-1:0] v, input int s);
    return int'(v[s*RW +: RW]);
  endfunction

  function automatic bit expCol();
    bit hit = 0;
    for (int s = 0; s < NS; s++) begin
      if (slotOf(colSrcRegs, s) != 0 && mPend[colWarp][slotOf(colSrcRegs, s)]) hit = 1;
      if (slotOf(colDstRegs, s) != 0 && mPend[colWarp][slotOf(colDstRegs, s)]) hit = 1;
    end
    return hit;
  endfunction

  function automatic bit expLong();
    return (llReg != 0) && mLong[llWarp][llReg];
  endfunction

  task automatic modelReset();
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++) begin
        mPend[w][r] = 0;
        mLong[w][r] = 0;
      end
  endtask

  task automatic modelUpdate();
    if (relValid) begin
      for (int s = 0; s < NS; s++)
        if (slotOf(relRegs, s) != 0) mPend[relWarp][slotOf(relRegs, s)] = 0;
      for (int r = 0; r < NR; r++) mLong[relWarp][r] = 0;
    end
    if (rsvValid) begin
      for (int s = 0; s < NS; s++)
        if (slotOf(rsvRegs, s) != 0) begin
          mPend[rsvWarp][slotOf(rsvRegs, s)] = 1;
          if (rsvIsLoad && (rsvSpace == 0 || rsvSpace == 1 || rsvSpace == 5))
            mLong[rsvWarp][slotOf(rsvRegs, s)] = 1;
        end
    end
  endtask

  // Compare both queries, then clock one cycle and advance the model
  task automatic tick(input string tag);
    bit ec, el;
    #1;
    ec = expCol();
    el = expLong();
    vectors++;
    if (colHit !== ec) begin
      miscompares++;
      $display("FAIL %s colHit actual=%0b expected=%0b (warp %0d)", tag, colHit, ec, colWarp);
    end
    vectors++;
    if (llHit !== el) begin
      miscompares++;
      $display("FAIL %s llHit actual=%0b expected=%0b (warp %0d reg %0d)", tag, llHit, el, llWarp, llReg);
    end
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    rsvValid = 0;
    relValid = 0;
  endtask

  function automatic logic [NS*RW-1:0] pack4(input int a, input int b, input int c, input int d);
    return {RW'(d), RW'(c), RW'(b), RW'(a)};
  endfunction

  task automatic query(input int w, input int r);
    colWarp = 4'(w); colSrcRegs = pack4(r, 0, 0, 0); colDstRegs = '0;
    llWarp = 4'(w); llReg = RW'(r);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 0;
    modelReset();
    // R1: everything clear after reset
    query(0, 1);  tick("R1");
    query(15, 63); tick("R1");

    // R2: plain reserve on warp 3, slot 2 unused
    rsvValid = 1; rsvWarp = 3; rsvRegs = pack4(5, 9, 0, 63); rsvIsLoad = 0; rsvSpace = 0;
    query(3, 5); tick("R2");
    query(3, 63); tick("R2");
    query(3, 9); tick("R4");   // non-load leaves long-latency clear

    // R3: global load, then texture load
    rsvValid = 1; rsvWarp = 3; rsvRegs = pack4(12, 13, 0, 0); rsvIsLoad = 1; rsvSpace = 0;
    query(3, 12); tick("R3");
    rsvValid = 1; rsvWarp = 7; rsvRegs = pack4(20, 0, 0, 0); rsvIsLoad = 1; rsvSpace = 5;
    query(3, 13); tick("R3");
    rsvValid = 1; rsvWarp = 8; rsvRegs = pack4(21, 0, 0, 0); rsvIsLoad = 1; rsvSpace = 1;
    query(7, 20); tick("R3");
    query(8, 21); tick("R3");

    // R4: shared, constant, parameter loads
    rsvValid = 1; rsvWarp = 4; rsvRegs = pack4(7, 0, 0, 0); rsvIsLoad = 1; rsvSpace = 2;
    tick("R4");
    rsvValid = 1; rsvWarp = 4; rsvRegs = pack4(8, 0, 0, 0); rsvIsLoad = 1; rsvSpace = 3;
    query(4, 7); tick("R4");
    rsvValid = 1; rsvWarp = 4; rsvRegs = pack4(10, 0, 0, 0); rsvIsLoad = 1; rsvSpace = 4;
    query(4, 8); tick("R4");
    query(4, 10); tick("R4");

    // R10: warp 5 untouched by all of the above
    query(5, 5); tick("R10");

    // R5/R6: release reg 5 on warp 3; reg 12 loses long tag but stays pending
    relValid = 1; relWarp = 3; relRegs = pack4(5, 0, 0, 0);
    query(3, 12); tick("R6");
    query(3, 5); tick("R5");
    query(3, 12); tick("R6");
    query(3, 9); tick("R5");
    query(7, 20); tick("R10");  // other warp keeps its long tag

    // R7: release and re-reserve reg 13 as global load on warp 3 in one cycle
    relValid = 1; relWarp = 3; relRegs = pack4(13, 0, 0, 0);
    rsvValid = 1; rsvWarp = 3; rsvRegs = pack4(13, 14, 0, 0); rsvIsLoad = 1; rsvSpace = 0;
    query(3, 13); tick("R7");
    query(3, 13); tick("R7");
    query(3, 14); tick("R11");
    // release on warp 7 while reserving on warp 8
    relValid = 1; relWarp = 7; relRegs = pack4(0, 0, 0, 0);
    rsvValid = 1; rsvWarp = 8; rsvRegs = pack4(22, 0, 0, 0); rsvIsLoad = 1; rsvSpace = 1;
    query(7, 20); tick("R10");
    query(7, 20); tick("R6");
    query(8, 22); tick("R7");

    // R8: destination-only and late-slot matches
    colWarp = 3; colSrcRegs = pack4(1, 2, 3, 0); colDstRegs = pack4(0, 0, 0, 63);
    llWarp = 3; llReg = 0; tick("R8");
    colSrcRegs = pack4(0, 0, 0, 9); colDstRegs = '0; tick("R8");
    colSrcRegs = pack4(1, 2, 3, 4); colDstRegs = pack4(6, 0, 11, 15); tick("R8");
    // R9: all-zero query and zero register in the long-latency query
    colSrcRegs = '0; colDstRegs = '0; tick("R9");
    rsvValid = 1; rsvWarp = 2; rsvRegs = pack4(0, 0, 0, 0); rsvIsLoad = 1; rsvSpace = 0;
    query(2, 0); tick("R9");
    query(2, 1); tick("R9");

    // Random mixed traffic over few warps and low registers
    for (int i = 0; i < 3000; i++) begin
      rsvValid = ($urandom_range(0, 2) != 0);
      rsvWarp = 4'($urandom_range(0, 3));
      rsvRegs = pack4($urandom_range(0, 15), $urandom_range(0, 15),
                      $urandom_range(0, 15), $urandom_range(0, 15));
      rsvIsLoad = 1'($urandom_range(0, 1));
      rsvSpace = 3'($urandom_range(0, 5));
      relValid = ($urandom_range(0, 2) == 0);
      relWarp = 4'($urandom_range(0, 3));
      relRegs = pack4($urandom_range(0, 15), $urandom_range(0, 15),
                      $urandom_range(0, 15), $urandom_range(0, 15));
      colWarp = 4'($urandom_range(0, 3));
      colSrcRegs = pack4($urandom_range(0, 15), $urandom_range(0, 15),
                         $urandom_range(0, 15), $urandom_range(0, 15));
      colDstRegs = pack4($urandom_range(0, 15), 0, 0, $urandom_range(0, 15));
      llWarp = 4'($urandom_range(0, 3));
      llReg = RW'($urandom_range(0, 15));
      tick("R8");
    end

    // R1: reset mid-run clears state
    rst = 1;
    @(posedge clk);
    modelReset();
    @(negedge clk);
    rst = 0;
    query(3, 12); tick("R1");
    query(8, 22); tick("R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule